// File: doc/BRIEF.md
# Oversampled Serial Receiver with Tagged Receive Words

This block turns an asynchronous serial line into 16-bit receive words. Each bit lasts sixteen pulses of an oversampling strobe supplied from outside. A synchroniser brings the line into the clock domain. A state machine then confirms the start bit at mid-bit, shifts in 5 to 8 data bits least significant bit first, checks an optional parity bit and samples the stop bit. The finished word goes into a two-entry buffer together with its own parity-error and framing-error tags. Software reads the words through a small register port.

The state machine has six states. RX_IDLE waits for a low line sample. RX_START checks the line at the eighth strobe and either falls back to RX_IDLE (glitch) or moves on to RX_DATA (start confirmed). RX_DATA samples one data bit every sixteen strobes. After the last data bit it goes to RX_PARITY if parity is enabled, and to RX_STOP if not. RX_PARITY samples the parity bit and then goes to RX_STOP. RX_STOP samples the first stop bit and pushes the word. A high stop bit returns the machine to RX_IDLE. A low stop bit sends it to RX_HOLD, which waits until the line is high again before RX_IDLE. While the receiver is disabled, every state falls back to RX_IDLE.

The frame format is taken from the same 16-bit frame-configuration word that the transmitter decodes. Two flags report events: data-valid and overflow. Each flag can be set, cleared and enabled through its own register, and any enabled flag that is set drives the interrupt output.

Top module: `serial_rx_core`

## Requirements
- R1: After reset the receiver is disabled, the buffer is empty, the flags and flag enables are all zero, and `irq` is low.
- R2: A write to address 0 with bit 0 set enables the receiver, and with bit 1 set disables it. When both bits are set, disable wins. Frames that arrive while the receiver is disabled leave no word.
- R3: The frame-configuration field [3:0] gives the number of data bits minus 3 (codes 2 to 5 give 5 to 8 bits; any other code gives 8 bits). Field [9:8] selects parity: 00 none, 10 even, 11 odd. Data arrives least significant bit first.
- R4: A receive word holds the data right-aligned in bits 8:0 with zeros above the data width. Bits 13:9 are zero, bit 14 is the parity-error tag and bit 15 is the framing-error tag (first stop bit sampled low).
- R5: A start bit counts only if the line is still low at the eighth strobe after the falling edge. A shorter low pulse produces no word.
- R6: Only the first stop bit is checked. A frame followed at once by the next start bit is accepted without a framing error, even when two stop bits are configured.
- R7: A break (line held low) gives exactly one word, 0x8000: framing error with all-zero data. The receiver then waits for the line to go high.
- R8: The buffer holds two words. Status at address 1 has bit 7 high while a word is waiting. A read of address 2 returns the oldest word and removes it. A read of address 2 with the buffer empty returns 0.
- R9: When a word completes while the buffer is full, the new word is discarded, the two buffered words are kept, and overflow flag bit 4 is set.
- R10: Flag bit 2 sets whenever a word is accepted. Flags read at address 3. A write to address 4 sets the flags given by the ones in the data, and a write to address 5 clears them. Address 6 holds the enables (read/write). `irq` is high when any enabled flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversampling strobe, sixteen per bit |
| rxd_pin | input | 1 | Serial input line, idle high |
| frame_cfg | input | 16 | Shared frame-configuration word |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on address 2) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational |
| irq | output | 1 | Interrupt: any enabled flag set |

## Verification
A table of frames is sent, mixing data widths of 5 to 8 bits, no, even and odd parity, one and two stop bits, and deliberately wrong parity or stop bits. The data values separate bit order and right-alignment errors. The error-tag values separate the parity and framing tags from each other and from the data field. Directed cases then cover back-to-back frames with two stop bits configured (only the first stop bit may be checked), three frames into the two-entry buffer (which word is dropped), a short low glitch against a real start bit, and a long low break (exactly one tagged word). Further directed cases cover flag set/clear/enable behaviour and the disable-wins command encoding.

// File: rtl/rx_pkg.sv
package rx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE   = 3'd0,
        RX_START  = 3'd1,
        RX_DATA   = 3'd2,
        RX_PARITY = 3'd3,
        RX_STOP   = 3'd4,
        RX_HOLD   = 3'd5
    } rx_state_e;

    localparam int WORD_W   = 16;
    localparam int DFIELD_W = 9;
    localparam int PERR_BIT = 14;
    localparam int FERR_BIT = 15;

    localparam int FLAG_W   = 5;
    localparam int FLAG_DV  = 2;
    localparam int FLAG_OVF = 4;
    localparam int STAT_AVL = 7;

    localparam logic [2:0] A_CMD    = 3'd0;
    localparam logic [2:0] A_STATUS = 3'd1;
    localparam logic [2:0] A_DATA   = 3'd2;
    localparam logic [2:0] A_FLAGS  = 3'd3;
    localparam logic [2:0] A_FSET   = 3'd4;
    localparam logic [2:0] A_FCLR   = 3'd5;
    localparam logic [2:0] A_FEN    = 3'd6;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
    import rx_pkg::*;
#(
    parameter int OSR  = 16,
    parameter int DMAX = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            tick,
    input  logic            rxd,
    input  logic [3:0]      size_code,
    input  logic [1:0]      par_mode,
    output logic            push,
    output logic [DMAX-1:0] data_o,
    output logic            perr_o,
    output logic            ferr_o,
    output rx_state_e       state_o
);
    localparam int CW = $clog2(OSR);
    localparam int IW = $clog2(DMAX + 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);
    localparam logic [CW-1:0] MIDC = CW'(OSR / 2 - 1);

    rx_state_e       state_q, state_d;
    logic [CW-1:0]   cnt;
    logic [IW-1:0]   idx;
    logic [IW-1:0]   nbits;
    logic [DMAX-1:0] shreg;
    logic            par_acc;
    logic            perr_q;
    logic            at_edge;

    always_comb begin
        int n;
        case (size_code)
            4'd2:    n = 5;
            4'd3:    n = 6;
            4'd4:    n = 7;
            default: n = 8;
        endcase
        if (n > DMAX) n = DMAX;
        nbits = IW'(n);
    end

    assign at_edge = tick && (cnt == LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:   if (tick && !rxd) state_d = RX_START;
            RX_START:  if (tick && cnt == MIDC) state_d = rxd ? RX_IDLE : RX_DATA;
            RX_DATA:   if (at_edge && idx == nbits - IW'(1))
                           state_d = par_mode[1] ? RX_PARITY : RX_STOP;
            RX_PARITY: if (at_edge) state_d = RX_STOP;
            RX_STOP:   if (at_edge) state_d = rxd ? RX_IDLE : RX_HOLD;
            RX_HOLD:   if (rxd) state_d = RX_IDLE;
            default:   state_d = RX_IDLE;
        endcase
        if (!en) state_d = RX_IDLE;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            idx     <= '0;
            shreg   <= '0;
            par_acc <= 1'b0;
            perr_q  <= 1'b0;
        end else begin
            unique case (state_q)
                RX_IDLE: begin
                    cnt     <= '0;
                    idx     <= '0;
                    shreg   <= '0;
                    par_acc <= 1'b0;
                    perr_q  <= 1'b0;
                end
                RX_START: if (tick) cnt <= (cnt == MIDC) ? '0 : cnt + CW'(1);
                RX_DATA: if (tick) begin
                    if (cnt == LAST) begin
                        cnt     <= '0;
                        shreg   <= {rxd, shreg[DMAX-1:1]};
                        par_acc <= par_acc ^ rxd;
                        idx     <= idx + IW'(1);
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                RX_PARITY: if (tick) begin
                    if (cnt == LAST) begin
                        cnt    <= '0;
                        perr_q <= par_acc ^ rxd ^ par_mode[0];
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                RX_STOP: if (tick) cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
                RX_HOLD: cnt <= '0;
                default: cnt <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        push    = en && (state_q == RX_STOP) && at_edge;
        ferr_o  = !rxd;
        perr_o  = perr_q;
        data_o  = shreg >> (DMAX - int'(nbits));
        state_o = state_q;
    end
endmodule

// File: rtl/rx_buffer.sv
module rx_buffer #(
    parameter int W     = 16,
    parameter int DEPTH = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   cnt_o,
    output logic                         accept_o,
    output logic                         drop_o
);
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [W-1:0]    mem [DEPTH];
    logic [PW-1:0]   wp, rp;
    logic [CNTW-1:0] cnt;
    logic            full, empty, pop_ok;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full     = (cnt == CNTW'(DEPTH));
    assign empty    = (cnt == '0);
    assign pop_ok   = pop && !empty;
    assign accept_o = push && (!full || pop_ok);
    assign drop_o   = push && !accept_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (accept_o) begin
                mem[wp] <= din;
                wp      <= nxt(wp);
            end
            if (pop_ok) rp <= nxt(rp);
            unique case ({accept_o, pop_ok})
                2'b10:   cnt <= cnt + CNTW'(1);
                2'b01:   cnt <= cnt - CNTW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assign dout  = mem[rp];
    assign cnt_o = cnt;
endmodule

// File: rtl/rx_flag_regs.sv
module rx_flag_regs #(
    parameter int              FW   = 5,
    parameter logic [FW-1:0]   MASK = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] hw_set,
    input  logic [FW-1:0] sw_set,
    input  logic [FW-1:0] sw_clr,
    input  logic          en_we,
    input  logic [FW-1:0] en_wd,
    output logic [FW-1:0] flags_o,
    output logic [FW-1:0] en_o,
    output logic          irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_o <= '0;
            en_o    <= '0;
        end else begin
            flags_o <= ((flags_o & ~sw_clr) | sw_set | hw_set) & MASK;
            if (en_we) en_o <= en_wd & MASK;
        end
    end

    assign irq = |(flags_o & en_o);
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import rx_pkg::*;
#(
    parameter int OSR       = 16,
    parameter int DMAX      = 8,
    parameter int BUF_DEPTH = 2,
    parameter int SYNC_FF   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick16,
    input  logic        rxd_pin,
    input  logic [15:0] frame_cfg,
    input  logic [2:0]  reg_addr,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq
);
    localparam int CNTW = $clog2(BUF_DEPTH + 1);
    localparam logic [FLAG_W-1:0] FMASK = FLAG_W'((1 << FLAG_DV) | (1 << FLAG_OVF));

    logic               rxd_s;
    logic               rx_en;
    logic               push, accept, drop, pop;
    logic [DMAX-1:0]    fr_data;
    logic               fr_perr, fr_ferr;
    rx_state_e          fsm_state;
    logic [WORD_W-1:0]  new_word, head_word;
    logic [CNTW-1:0]    buf_cnt;
    logic [FLAG_W-1:0]  flags, flag_en, hw_set, sw_set, sw_clr;
    logic               en_we;
    logic               unused_bits;

    assign unused_bits = ^{frame_cfg[15:10], frame_cfg[7:4], reg_wdata[15:5]};

    rx_sync #(.STAGES(SYNC_FF)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(rxd_pin), .q(rxd_s)
    );

    rx_framer #(.OSR(OSR), .DMAX(DMAX)) u_framer (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(tick16), .rxd(rxd_s),
        .size_code(frame_cfg[3:0]), .par_mode(frame_cfg[9:8]),
        .push(push), .data_o(fr_data), .perr_o(fr_perr), .ferr_o(fr_ferr),
        .state_o(fsm_state)
    );

    always_comb begin
        new_word = '0;
        new_word[DFIELD_W-1:0] = DFIELD_W'(fr_data);
        new_word[PERR_BIT]     = fr_perr;
        new_word[FERR_BIT]     = fr_ferr;
    end

    assign pop = reg_rd && (reg_addr == A_DATA);

    rx_buffer #(.W(WORD_W), .DEPTH(BUF_DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n), .push(push), .din(new_word), .pop(pop),
        .dout(head_word), .cnt_o(buf_cnt), .accept_o(accept), .drop_o(drop)
    );

    // receiver enable command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_en <= 1'b0;
        else if (reg_wr && reg_addr == A_CMD) begin
            if (reg_wdata[1])      rx_en <= 1'b0;
            else if (reg_wdata[0]) rx_en <= 1'b1;
        end
    end

    always_comb begin
        hw_set = '0;
        hw_set[FLAG_DV]  = accept;
        hw_set[FLAG_OVF] = drop;
        sw_set = (reg_wr && reg_addr == A_FSET) ? reg_wdata[FLAG_W-1:0] : '0;
        sw_clr = (reg_wr && reg_addr == A_FCLR) ? reg_wdata[FLAG_W-1:0] : '0;
        en_we  = reg_wr && reg_addr == A_FEN;
    end

    rx_flag_regs #(.FW(FLAG_W), .MASK(FMASK)) u_flags (
        .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .sw_set(sw_set),
        .sw_clr(sw_clr), .en_we(en_we), .en_wd(reg_wdata[FLAG_W-1:0]),
        .flags_o(flags), .en_o(flag_en), .irq(irq)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_STATUS: reg_rdata[STAT_AVL] = (buf_cnt != '0);
            A_DATA:   reg_rdata = (buf_cnt != '0) ? head_word : '0;
            A_FLAGS:  reg_rdata = WORD_W'(flags);
            A_FEN:    reg_rdata = WORD_W'(flag_en);
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rx_core_chk.sv
module rx_core_chk
    import rx_pkg::*;
#(
    parameter int DEPTH = 2,
    parameter int CNTW  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en,
    input rx_state_e         fsm_state,
    input logic              push,
    input logic              pop,
    input logic [CNTW-1:0]   buf_cnt,
    input logic [15:0]       head_word,
    input logic [4:0]        flags,
    input logic              reg_wr,
    input logic [2:0]        reg_addr,
    input logic [15:0]       reg_wdata
);
    logic full_drop;
    assign full_drop = push && (buf_cnt == CNTW'(DEPTH)) && !pop;

    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> fsm_state == RX_IDLE); // R2
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        buf_cnt != '0 |-> head_word[13:9] == 5'd0); // R4
    AST_OVF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        full_drop |=> buf_cnt == CNTW'(DEPTH) && $stable(head_word)); // R9
    AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        full_drop |=> flags[FLAG_OVF]); // R9
    AST_DV_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        push && !full_drop |=> flags[FLAG_DV]); // R10
    AST_CLR_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == A_FCLR && reg_wdata[FLAG_OVF] && !full_drop |=> !flags[FLAG_OVF]); // R10
    AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        buf_cnt == CNTW'(1) && pop && !push |=> buf_cnt == '0); // R8
endmodule

bind serial_rx_core rx_core_chk #(.DEPTH(BUF_DEPTH), .CNTW(CNTW)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .fsm_state(fsm_state),
    .push(push), .pop(pop), .buf_cnt(buf_cnt), .head_word(head_word),
    .flags(flags), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/tb_serial_rx_core.sv
`timescale 1ns/1ps
module tb_serial_rx_core;
    localparam logic [2:0] AC = 3'd0, AS = 3'd1, AD = 3'd2, AF = 3'd3,
                           AFS = 3'd4, AFC = 3'd5, AFE = 3'd6;

    typedef struct packed {
        logic [3:0] nb;
        logic [1:0] par;
        logic       two;
        logic [7:0] data;
        logic       badp;
        logic       bads;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{4'd8, 2'd0, 1'b0, 8'hA5, 1'b0, 1'b0},
        '{4'd5, 2'd0, 1'b0, 8'h13, 1'b0, 1'b0},
        '{4'd7, 2'd2, 1'b0, 8'h55, 1'b0, 1'b0},
        '{4'd6, 2'd3, 1'b1, 8'h2A, 1'b0, 1'b0},
        '{4'd8, 2'd2, 1'b0, 8'h81, 1'b1, 1'b0},
        '{4'd8, 2'd3, 1'b0, 8'h00, 1'b0, 1'b1},
        '{4'd7, 2'd3, 1'b1, 8'h7F, 1'b1, 1'b0},
        '{4'd5, 2'd2, 1'b0, 8'hFF, 1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick16 = 1'b1;
    logic        rxd_pin = 1'b1;
    logic [15:0] frame_cfg = 16'h0;
    logic [2:0]  reg_addr = 3'd0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        irq;

    int total = 0;
    int failed = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    serial_rx_core dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd_pin(rxd_pin),
        .frame_cfg(frame_cfg), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        rxd_pin = b;
        repeat (16) @(negedge clk);
    endtask

    function automatic logic [15:0] cfg(input logic [3:0] nb, input logic [1:0] par, input logic two);
        return {2'b00, two ? 2'b11 : 2'b01, 2'b00, par, 4'b0000, nb - 4'd3};
    endfunction

    task automatic send_frame(input logic [3:0] nb, input logic [1:0] par, input int nstop,
                              input logic [7:0] data, input logic badp, input logic bads,
                              input int gap);
        logic [7:0] md;
        md = data & 8'((9'h1 << nb) - 9'h1);
        @(negedge clk);
        send_bit(1'b0);
        for (int i = 0; i < int'(nb); i++) send_bit(md[i]);
        if (par[1]) send_bit((^md) ^ par[0] ^ badp);
        send_bit(!bads);
        if (nstop == 2) send_bit(1'b1);
        rxd_pin = 1'b1;
        repeat (gap) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; failed++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        logic [15:0] exp;
        logic [7:0]  m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        frame_cfg = cfg(4'd8, 2'd0, 1'b0);

        // R1 reset state
        rd(AS, v);  check(v, 16'h0000, "R1 status");
        rd(AF, v);  check(v, 16'h0000, "R1 flags");
        rd(AFE, v); check(v, 16'h0000, "R1 enables");
        check({15'd0, irq}, 16'h0000, "R1 irq");
        rd(AD, v);  check(v, 16'h0000, "R8 empty read");

        // R2 frame while disabled is dropped
        send_frame(4'd8, 2'd0, 1, 8'h5A, 1'b0, 1'b0, 30);
        rd(AS, v);  check(v, 16'h0000, "R2 disabled drop");
        wr(AC, 16'h0001);

        // R3 R4 vector table
        foreach (VEC[k]) begin
            frame_cfg = cfg(VEC[k].nb, VEC[k].par, VEC[k].two);
            m = VEC[k].data & 8'((9'h1 << VEC[k].nb) - 9'h1);
            exp = {VEC[k].bads, VEC[k].badp & VEC[k].par[1], 6'd0, m};
            send_frame(VEC[k].nb, VEC[k].par, VEC[k].two ? 2 : 1, VEC[k].data,
                       VEC[k].badp, VEC[k].bads, 30);
            rd(AS, v); check(v, 16'h0080, "R8 avail");
            rd(AD, v); check(v, exp, "R3/R4 word");
            rd(AS, v); check(v, 16'h0000, "R8 popped");
        end
        rd(AF, v); check(v, 16'h0004, "R10 dv flag");
        wr(AFC, 16'h0014);
        rd(AF, v); check(v, 16'h0000, "R10 clear");

        // R6 two stops configured, back-to-back single-stop frames
        frame_cfg = cfg(4'd8, 2'd0, 1'b1);
        send_frame(4'd8, 2'd0, 1, 8'h3C, 1'b0, 1'b0, 0);
        send_frame(4'd8, 2'd0, 1, 8'hC3, 1'b0, 1'b0, 30);
        rd(AD, v); check(v, 16'h003C, "R6 first");
        rd(AD, v); check(v, 16'h00C3, "R6 second");

        // R9 overflow
        frame_cfg = cfg(4'd8, 2'd0, 1'b0);
        send_frame(4'd8, 2'd0, 1, 8'h11, 1'b0, 1'b0, 10);
        send_frame(4'd8, 2'd0, 1, 8'h22, 1'b0, 1'b0, 10);
        send_frame(4'd8, 2'd0, 1, 8'h33, 1'b0, 1'b0, 30);
        rd(AF, v); check(v, 16'h0014, "R9 ovf flag");
        rd(AD, v); check(v, 16'h0011, "R9 kept oldest");
        rd(AD, v); check(v, 16'h0022, "R9 kept second");
        rd(AS, v); check(v, 16'h0000, "R9 third dropped");
        wr(AFC, 16'h0014);

        // R5 glitch shorter than half a bit
        @(negedge clk);
        rxd_pin = 1'b0;
        repeat (4) @(negedge clk);
        rxd_pin = 1'b1;
        repeat (300) @(negedge clk);
        rd(AS, v); check(v, 16'h0000, "R5 glitch ignored");

        // R7 break
        rxd_pin = 1'b0;
        repeat (400) @(negedge clk);
        rxd_pin = 1'b1;
        repeat (40) @(negedge clk);
        rd(AD, v); check(v, 16'h8000, "R7 break word");
        rd(AS, v); check(v, 16'h0000, "R7 single word");

        // R10 set, enable, irq
        wr(AFC, 16'h0014);
        wr(AFS, 16'h0010);
        rd(AF, v); check(v, 16'h0010, "R10 set");
        check({15'd0, irq}, 16'h0000, "R10 irq masked");
        wr(AFE, 16'h0010);
        rd(AFE, v); check(v, 16'h0010, "R10 enable readback");
        check({15'd0, irq}, 16'h0001, "R10 irq on");
        wr(AFC, 16'h0010);
        check({15'd0, irq}, 16'h0000, "R10 irq off");

        // R2 disable wins
        wr(AC, 16'h0003);
        send_frame(4'd8, 2'd0, 1, 8'h77, 1'b0, 1'b0, 30);
        rd(AS, v); check(v, 16'h0000, "R2 disable wins");
        wr(AC, 16'h0001);
        send_frame(4'd8, 2'd0, 1, 8'h77, 1'b0, 1'b0, 30);
        rd(AD, v); check(v, 16'h0077, "R2 re-enabled");

        finish_run();
    end
endmodule